// File: doc/BRIEF.md
# Split Transaction Micro-frame Scheduler

This block makes the per-micro-frame scheduling decision for a single periodic endpoint of a bus host. At each micro-frame boundary it looks at the current micro-frame number, the endpoint's speed code and two 8-bit masks. It then decides whether to issue a plain high-speed transaction, a start-split, a complete-split, or nothing. When it issues, it raises a one-cycle request that carries the transaction kind.

A transaction engine outside the block carries out the request and reports the outcome on three result strobes: acknowledged, no-data, or error. A high-speed transfer moves forward on the acknowledge of its single transaction. A split transfer moves forward only after its start-split and its complete-split have both finished. A small progress state follows the split. If the complete-split window runs out without a successful completion, the block raises a lost-data pulse.

All pins are plain control and status signals: the block has no streaming data path and no back-pressure. A result strobe that arrives in the same cycle as a micro-frame tick is not considered; the engine reports results between ticks.

Top module: `split_uframe_sched`

## Requirements
- R1: Speed code 2'b10 selects high-speed mode. In that mode, at a tick whose micro-frame bit is set in `start_mask`, the block issues kind 2'd0 (plain). Every other speed code selects split mode, which never issues kind 2'd0.
- R2: `issue_valid` is a one-cycle pulse in the cycle after `uf_tick` is sampled high. There is at most one pulse per tick. Kinds are 0 plain, 1 start-split and 2 complete-split.
- R3: A start-split (kind 1) is issued only from the idle state, at a tick whose micro-frame bit is set in `start_mask`. It moves the progress state to start-issued and records the micro-frame.
- R4: In start-issued, an acknowledge moves the state to completing. A no-data reply, or a tick with no reply, returns the state to idle with no advance and no error.
- R5: A complete-split (kind 2) is issued only in completing, at a tick whose bit is set in `cmpl_mask`. A no-data reply keeps completing, so a retry follows at the next masked micro-frame.
- R6: `xfer_advance` pulses one cycle after an acknowledge of a plain transaction, or after an acknowledge of a complete-split. It never pulses for any other outcome.
- R7: At a tick in completing, the window is closed if the micro-frame number is not greater than the start-split's micro-frame, or if no `cmpl_mask` bit is set at or above it. When the window is closed, `lost_data` pulses in the cycle after the tick, the state returns to idle, and the block issues nothing and does not advance.
- R8: An error reply to any outstanding transaction pulses `split_err` one cycle later. The state returns to idle and the transfer does not advance.
- R9: Result strobes are honoured only while a transaction issued at the latest tick is unanswered. Strobes at any other time have no effect. When strobes arrive together, error wins over acknowledge, and acknowledge wins over no-data.
- R10: While `rst_n` is low, every output is low and the state is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uf_tick | input | 1 | One-cycle strobe at a micro-frame boundary |
| uf_idx | input | 3 | Micro-frame number within the frame |
| ep_speed | input | 2 | Endpoint speed code, 2'b10 high-speed |
| start_mask | input | 8 | Poll mask (high-speed) or start-split mask |
| cmpl_mask | input | 8 | Complete-split mask |
| rsp_ack | input | 1 | Outstanding transaction acknowledged |
| rsp_nodata | input | 1 | Outstanding transaction got no data yet |
| rsp_err | input | 1 | Outstanding transaction failed |
| issue_valid | output | 1 | Issue request pulse |
| issue_kind | output | 2 | Kind of the request |
| xfer_advance | output | 1 | Transfer-advance pulse |
| lost_data | output | 1 | Complete-split window expired |
| split_err | output | 1 | Error reply seen |

## Verification
The bench targets four cases.
- Window expiry: the bench runs a complete-split mask that ends early, one that is empty, and one whose only bit sits below the start micro-frame so the window wraps into the next frame. A design that tests only the current mask bit would wait in completing forever and never raise `lost_data`.
- Error priority: an error that arrives together with an acknowledge must not advance the transfer. A design with the priority reversed would pulse `xfer_advance`.
- Stray strobes: the bench sends result strobes when nothing is outstanding. A design that does not track the outstanding transaction would advance or move state on them.
- Start-split outcome: a start-split that is only half finished must not advance, so a no-data reply to it must return to idle quietly. A design that counts any acknowledge would advance after the start phase alone.

// File: rtl/psched_pkg.sv
package psched_pkg;

  typedef enum logic [1:0] {
    XK_PLAIN  = 2'd0,
    XK_SSPLIT = 2'd1,
    XK_CSPLIT = 2'd2
  } xkind_t;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_START = 2'd1,
    PS_CMPL  = 2'd2
  } pstate_t;

  localparam logic [1:0] SPD_HIGH = 2'b10;

endpackage

// File: rtl/uframe_mask_eval.sv
module uframe_mask_eval #(
  parameter int UF_N = 8,
  localparam int IDX_W = $clog2(UF_N)
) (
  input  logic [UF_N-1:0]  start_mask,
  input  logic [UF_N-1:0]  cmpl_mask,
  input  logic [IDX_W-1:0] cur_uf,
  input  logic [IDX_W-1:0] start_uf,
  output logic             s_hit,
  output logic             c_hit,
  output logic             c_window
);

  // complete-mask bits at or after the current micro-frame
  logic [UF_N-1:0] c_tail;

  for (genvar g = 0; g < UF_N; g++) begin : g_tail
    assign c_tail[g] = cmpl_mask[g] && (IDX_W'(g) >= cur_uf);
  end

  assign s_hit    = start_mask[cur_uf];
  assign c_hit    = cmpl_mask[cur_uf];
  assign c_window = (cur_uf > start_uf) && (|c_tail);

endmodule

// File: rtl/split_progress.sv
module split_progress
  import psched_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [IDX_W-1:0] cur_uf,
  input  logic             split_mode,
  input  logic             s_hit,
  input  logic             c_hit,
  input  logic             c_window,
  input  logic             rsp_ack,
  input  logic             rsp_nodata,
  input  logic             rsp_err,
  output logic [IDX_W-1:0] start_uf,
  output logic             issue_valid,
  output xkind_t           issue_kind,
  output logic             advance,
  output logic             lost,
  output logic             err_pulse
);

  pstate_t state;
  logic    pend;
  logic    any_rsp;

  assign any_rsp = rsp_ack | rsp_nodata | rsp_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= PS_IDLE;
      pend        <= 1'b0;
      start_uf    <= '0;
      issue_valid <= 1'b0;
      issue_kind  <= XK_PLAIN;
      advance     <= 1'b0;
      lost        <= 1'b0;
      err_pulse   <= 1'b0;
    end else begin
      issue_valid <= 1'b0;
      advance     <= 1'b0;
      lost        <= 1'b0;
      err_pulse   <= 1'b0;
      if (tick) begin
        pend <= 1'b0;
        if (!split_mode) begin
          state <= PS_IDLE;
          if (s_hit) begin
            issue_valid <= 1'b1;
            issue_kind  <= XK_PLAIN;
            pend        <= 1'b1;
          end
        end else begin
          case (state)
            PS_IDLE: if (s_hit) begin
              issue_valid <= 1'b1;
              issue_kind  <= XK_SSPLIT;
              pend        <= 1'b1;
              start_uf    <= cur_uf;
              state       <= PS_START;
            end
            PS_START: state <= PS_IDLE;
            PS_CMPL: begin
              if (!c_window) begin
                lost  <= 1'b1;
                state <= PS_IDLE;
              end else if (c_hit) begin
                issue_valid <= 1'b1;
                issue_kind  <= XK_CSPLIT;
                pend        <= 1'b1;
              end
            end
            default: state <= PS_IDLE;
          endcase
        end
      end else if (pend && any_rsp) begin
        pend <= 1'b0;
        if (rsp_err) begin
          err_pulse <= 1'b1;
          state     <= PS_IDLE;
        end else if (rsp_ack) begin
          if (!split_mode) begin
            advance <= 1'b1;
          end else if (state == PS_START) begin
            state <= PS_CMPL;
          end else if (state == PS_CMPL) begin
            advance <= 1'b1;
            state   <= PS_IDLE;
          end
        end else if (state == PS_START) begin
          state <= PS_IDLE;
        end
      end
    end
  end

  AST_ISSUE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> $past(tick)); // R2
  AST_PLAIN_ONLY_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_kind == XK_PLAIN) |-> !$past(split_mode)); // R1
  AST_SSPLIT_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_kind == XK_SSPLIT) |-> ($past(state) == PS_IDLE && $past(s_hit))); // R3
  AST_CSPLIT_IN_CMPL: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_kind == XK_CSPLIT) |-> ($past(state) == PS_CMPL && $past(c_hit))); // R5
  AST_ADV_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> ($past(pend) && $past(rsp_ack) && !$past(rsp_err))); // R6
  AST_LOST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    lost |-> (state == PS_IDLE && !issue_valid && !advance)); // R7
  AST_ERR_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (state == PS_IDLE && !advance)); // R8
  AST_START_RESOLVES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == PS_START && $past(tick)) |-> state == PS_IDLE); // R4

endmodule

// File: rtl/split_uframe_sched.sv
module split_uframe_sched
  import psched_pkg::*;
#(
  parameter int UF_N = 8,
  localparam int IDX_W = $clog2(UF_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uf_tick,
  input  logic [IDX_W-1:0] uf_idx,
  input  logic [1:0]       ep_speed,
  input  logic [UF_N-1:0]  start_mask,
  input  logic [UF_N-1:0]  cmpl_mask,
  input  logic             rsp_ack,
  input  logic             rsp_nodata,
  input  logic             rsp_err,
  output logic             issue_valid,
  output logic [1:0]       issue_kind,
  output logic             xfer_advance,
  output logic             lost_data,
  output logic             split_err
);

  logic             split_mode;
  logic             s_hit;
  logic             c_hit;
  logic             c_window;
  logic [IDX_W-1:0] start_uf;
  xkind_t           kind_q;

  assign split_mode = (ep_speed != SPD_HIGH);
  assign issue_kind = kind_q;

  uframe_mask_eval #(.UF_N(UF_N)) u_mask (
    .start_mask (start_mask),
    .cmpl_mask  (cmpl_mask),
    .cur_uf     (uf_idx),
    .start_uf   (start_uf),
    .s_hit      (s_hit),
    .c_hit      (c_hit),
    .c_window   (c_window)
  );

  split_progress #(.IDX_W(IDX_W)) u_prog (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (uf_tick),
    .cur_uf      (uf_idx),
    .split_mode  (split_mode),
    .s_hit       (s_hit),
    .c_hit       (c_hit),
    .c_window    (c_window),
    .rsp_ack     (rsp_ack),
    .rsp_nodata  (rsp_nodata),
    .rsp_err     (rsp_err),
    .start_uf    (start_uf),
    .issue_valid (issue_valid),
    .issue_kind  (kind_q),
    .advance     (xfer_advance),
    .lost        (lost_data),
    .err_pulse   (split_err)
  );

  AST_EXCLUSIVE_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xfer_advance, lost_data, split_err})); // R9

endmodule

// File: tb/split_uframe_sched_bench.sv
`timescale 1ns/1ps
module split_uframe_sched_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       uf_tick;
  logic [2:0] uf_idx;
  logic [1:0] ep_speed;
  logic [7:0] start_mask;
  logic [7:0] cmpl_mask;
  logic       rsp_ack, rsp_nodata, rsp_err;
  logic       issue_valid;
  logic [1:0] issue_kind;
  logic       xfer_advance, lost_data, split_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // reference model state: 0 idle, 1 start-issued, 2 completing
  int m_state;
  int m_start;
  bit m_pend;

  always #2.5 clk = ~clk;

  split_uframe_sched u_split_uframe_sched (
    .clk(clk), .rst_n(rst_n), .uf_tick(uf_tick), .uf_idx(uf_idx),
    .ep_speed(ep_speed), .start_mask(start_mask), .cmpl_mask(cmpl_mask),
    .rsp_ack(rsp_ack), .rsp_nodata(rsp_nodata), .rsp_err(rsp_err),
    .issue_valid(issue_valid), .issue_kind(issue_kind),
    .xfer_advance(xfer_advance), .lost_data(lost_data), .split_err(split_err)
  );

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; uf_tick = 1'b0; uf_idx = '0;
    rsp_ack = 1'b0; rsp_nodata = 1'b0; rsp_err = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 issue_valid in reset", issue_valid, 0);
    check("R10 pulses in reset", {xfer_advance, lost_data, split_err}, 0);
    rst_n = 1'b1;
    m_state = 0; m_start = 0; m_pend = 0;
    @(negedge clk);
  endtask

  // resp: 0 none, 1 ack, 2 no-data, 3 error, 4 error and ack together
  task automatic uframe(int idx, int resp);
    bit    split = (ep_speed != 2'b10);
    bit    e_issue = 0, e_lost = 0, e_adv = 0, e_err = 0;
    int    e_kind = 0;
    int    st_before;
    bit    pend_before;
    string tag;
    if (!split) begin
      m_state = 0;
      if (start_mask[idx]) begin e_issue = 1; e_kind = 0; end
    end else begin
      case (m_state)
        0: if (start_mask[idx]) begin
             e_issue = 1; e_kind = 1; m_state = 1; m_start = idx;
           end
        1: m_state = 0;
        default: begin
          if (!(idx > m_start && (cmpl_mask >> idx) != 0)) begin
            e_lost = 1; m_state = 0;
          end else if (cmpl_mask[idx]) begin
            e_issue = 1; e_kind = 2;
          end
        end
      endcase
    end
    m_pend = e_issue;
    uf_tick = 1'b1; uf_idx = 3'(idx);
    @(negedge clk);
    uf_tick = 1'b0;
    tag = e_issue ? (e_kind == 0 ? "R1 plain issue" : e_kind == 1 ? "R3 start-split issue" : "R5 complete-split issue")
                  : (e_lost ? "R7 no issue at window end" : "R2 no issue");
    check(tag, issue_valid, e_issue);
    if (e_issue) check({tag, " kind"}, issue_kind, e_kind);
    check("R7 lost_data", lost_data, e_lost);
    check("R6 no advance at tick", xfer_advance, 0);
    st_before = m_state; pend_before = m_pend;
    rsp_ack    = (resp == 1 || resp == 4);
    rsp_nodata = (resp == 2);
    rsp_err    = (resp == 3 || resp == 4);
    if (resp != 0 && m_pend) begin
      if (rsp_err) begin e_err = 1; m_state = 0; end
      else if (rsp_ack) begin
        if (!split) e_adv = 1;
        else if (m_state == 1) m_state = 2;
        else if (m_state == 2) begin e_adv = 1; m_state = 0; end
      end else if (m_state == 1) m_state = 0;
      m_pend = 0;
    end
    @(negedge clk);
    rsp_ack = 1'b0; rsp_nodata = 1'b0; rsp_err = 1'b0;
    tag = !pend_before || resp == 0 ? "R9 strobe ignored"
        : (resp >= 3) ? "R8 error reply"
        : (st_before == 1) ? "R4 start-split reply" : "R6 reply";
    check({tag, " advance"}, xfer_advance, e_adv);
    check({tag, " split_err"}, split_err, e_err);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    ep_speed = 2'b10; start_mask = '0; cmpl_mask = '0;
    do_reset();

    // R1 R6: high-speed polling on micro-frames 0 and 2
    start_mask = 8'b0000_0101;
    uframe(0, 1); uframe(1, 1); uframe(2, 1); uframe(3, 2);

    // R3 R4 R5 R6: normal split with one no-data retry
    ep_speed = 2'b00; do_reset();
    start_mask = 8'b0000_0010; cmpl_mask = 8'b0011_1000;
    uframe(1, 1); uframe(2, 1); uframe(3, 2); uframe(4, 1); uframe(5, 1);

    // R7: last complete micro-frame answers no-data
    do_reset();
    start_mask = 8'b0000_0001; cmpl_mask = 8'b0000_0100;
    uframe(0, 1); uframe(1, 0); uframe(2, 2); uframe(3, 0);

    // R8 R9: error and ack together on a complete-split
    ep_speed = 2'b01; do_reset();
    start_mask = 8'b0000_0001; cmpl_mask = 8'b0000_0110;
    uframe(0, 1); uframe(1, 4); uframe(2, 1);

    // R7: empty complete mask, then wrap into next frame
    do_reset();
    cmpl_mask = 8'b0000_0000;
    uframe(0, 1); uframe(1, 0);
    start_mask = 8'b0100_0000; cmpl_mask = 8'b0000_0001;
    uframe(6, 1); uframe(7, 0); uframe(0, 1);

    // R4: start-split no-data returns to idle
    do_reset();
    start_mask = 8'b0000_0011; cmpl_mask = 8'b1000_0000;
    uframe(0, 2); uframe(1, 1); uframe(7, 1);

    // random segments
    for (int seg = 0; seg < 40; seg++) begin
      int sel = $urandom % 3;
      ep_speed = (sel == 0) ? 2'b10 : (sel == 1) ? 2'b00 : 2'b01;
      do_reset();
      start_mask = 8'($urandom);
      cmpl_mask  = 8'($urandom);
      for (int k = 0; k < 24; k++) uframe(k % 8, $urandom % 5);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule